// File: doc/BRIEF.md
# Serial Channel External-Status Monitor

This block watches the slow-changing condition inputs of one serial channel and turns them into a status byte and a single interrupt request. It covers three modem-style pins: clear-to-send, carrier detect and the sync/hunt pin. It also covers two conditions that come from the rest of the channel: break/abort detection from the receiver, and a transmit-underrun / end-of-message latch.

The three pins are asynchronous. Each passes through a synchronizer, and an edge on an enabled pin is compared against a per-pin latch. When no interrupt is pending, a difference sets the request and captures the pin level. While the request is pending, the latch is frozen and the status byte shows the captured level. A clear command then reopens the latch, and any pin that now differs from its captured value raises the request again.

Break/abort and underrun behave as events and are not frozen. Both edges of break/abort raise the request. Only the setting of the underrun latch raises it. The underrun latch is cleared only by a dedicated command.

Top module: `ext_status_monitor`

## Requirements
- R1: Immediately after reset the request output is low and the status byte reads 0x40: underrun set, all other bits clear. The status byte layout is break/abort at bit 7, underrun at bit 6, clear-to-send at bit 5, sync/hunt at bit 4 and carrier detect at bit 3, with bits 2..0 always zero. The enable mask bits are 0 clear-to-send, 1 carrier detect, 2 sync/hunt, 3 break/abort and 4 underrun.
- R2: With a pin's enable set and no request pending, a change of that pin's synchronized level raises the request. The status bit then holds the captured level until the clear command, whatever the pin does meanwhile.
- R3: After the clear command, a pin whose level differs from its captured value re-raises the request one cycle later. This covers any odd number of transitions made while pending. An even number of transitions leaves the request low.
- R4: With a pin's enable clear, its status bit shows the live pin level two clock cycles after the pin changes, and the pin never raises the request.
- R5: With its enable set, each rising and each falling transition of break/abort raises the request. A break/abort transition that coincides with the clear command leaves the request asserted. The break/abort status bit always tracks the condition, one cycle after the input.
- R6: The underrun bit is set by reset, by an underrun pulse, by the send-abort command, or by a falling edge of the transmit enable. It is cleared only by the clear-underrun command, and a set in the same cycle takes priority over that clear.
- R7: Only a 0-to-1 change of the underrun bit raises the request, and only when its enable is set. A clear of the bit, or a set of a bit already at 1, raises nothing.
- R8: While asynchronous mode and crystal-oscillator select are both high, the sync/hunt status bit reads 0 and the sync pin raises no request.
- R9: The request is a level that stays asserted from the cycle after a trigger until a cycle in which the clear command is applied with no new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (hardware/channel reset) |
| clear_to_send_i | input | 1 | Clear-to-send pin, asynchronous |
| carrier_det_i | input | 1 | Carrier-detect pin, asynchronous |
| sync_pin_i | input | 1 | Sync/hunt pin, asynchronous |
| brk_abort_i | input | 1 | Break/abort condition level from the receiver, synchronous |
| tx_underrun_i | input | 1 | One-cycle pulse: transmitter underran |
| tx_enable_i | input | 1 | Transmitter enable level; its falling edge sets the underrun bit |
| send_abort_i | input | 1 | Send-abort command strobe; sets the underrun bit |
| clr_underrun_i | input | 1 | Clear-underrun command strobe |
| clr_ext_irq_i | input | 1 | Clear external-status request command strobe |
| async_mode_i | input | 1 | Channel is in asynchronous mode |
| xtal_sel_i | input | 1 | Crystal-oscillator option selected |
| ie_mask_i | input | 5 | Per-source interrupt enables (bit map in R1) |
| status_o | output | 8 | Status byte (layout in R1) |
| ext_irq_o | output | 1 | External-status interrupt request, level |

## Verification
The hardest case to reach from the ports is a break/abort edge that lands in exactly the cycle where the clear command is taken. The edge is seen one register after the input changes, so the stimulus drops break/abort and then applies the clear strobe one cycle later, making the two meet at the same edge. Counting transitions while a request is pending is the other subtle case. The stimulus toggles clear-to-send once, and later twice, between trigger and clear, then compares the re-raise behaviour. A long randomized run of pins, strobes, mode bits and enables is compared on every cycle against a behavioural model.

// File: rtl/ext_stat_pkg.sv
package ext_stat_pkg;
  // status byte bit positions (software decodes these)
  localparam int unsigned BIT_DCD  = 3;
  localparam int unsigned BIT_SYNC = 4;
  localparam int unsigned BIT_CTS  = 5;
  localparam int unsigned BIT_URUN = 6;
  localparam int unsigned BIT_BRK  = 7;
  localparam int unsigned STAT_W   = 8;
  // source indices into the enable mask
  localparam int unsigned SRC_CTS  = 0;
  localparam int unsigned SRC_DCD  = 1;
  localparam int unsigned SRC_SYNC = 2;
  localparam int unsigned SRC_BRK  = 3;
  localparam int unsigned SRC_URUN = 4;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned NUM_LVL  = 3;  // pin sources that latch
endpackage

// File: rtl/esm_sync.sv
module esm_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= g_stg[g-1].q;
    end
  end
  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/esm_level_src.sv
module esm_level_src (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,   // synchronized level
  input  logic arm_i,    // may trigger
  input  logic ie_i,     // enable: selects latched view
  input  logic hold_i,   // request pending: latch frozen
  output logic trig_o,
  output logic shown_o
);
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lat_q <= 1'b0;
    else if (!hold_i) lat_q <= live_i;

  assign trig_o  = arm_i & ~hold_i & (live_i ^ lat_q);
  assign shown_o = (ie_i & hold_i) ? lat_q : live_i;

  // R2
  lat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(lat_q));
endmodule

// File: rtl/esm_event_src.sv
module esm_event_src (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  input  logic ie_brk_i,
  input  logic ie_urun_i,
  input  logic urun_evt_i,
  input  logic send_abort_i,
  input  logic clr_urun_i,
  input  logic tx_en_i,
  output logic brk_bit_o,
  output logic urun_bit_o,
  output logic brk_trig_o,
  output logic urun_trig_o
);
  logic brk_q, brk_prev, urun_q, tx_en_q;
  logic urun_set;

  assign urun_set = urun_evt_i | send_abort_i | (tx_en_q & ~tx_en_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk_q    <= 1'b0;
      brk_prev <= 1'b0;
      urun_q   <= 1'b1;
      tx_en_q  <= 1'b1;
    end else begin
      brk_q    <= brk_i;
      brk_prev <= brk_q;
      tx_en_q  <= tx_en_i;
      if (urun_set)        urun_q <= 1'b1;
      else if (clr_urun_i) urun_q <= 1'b0;
    end

  assign brk_trig_o  = ie_brk_i & (brk_q ^ brk_prev);
  assign urun_trig_o = ie_urun_i & urun_set & ~urun_q;
  assign brk_bit_o   = brk_q;
  assign urun_bit_o  = urun_q;

  // R6
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q && !clr_urun_i |=> urun_q);
  // R6
  urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urun_evt_i || send_abort_i |=> urun_q);
endmodule

// File: rtl/ext_status_monitor.sv
module ext_status_monitor
  import ext_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_to_send_i,
  input  logic               carrier_det_i,
  input  logic               sync_pin_i,
  input  logic               brk_abort_i,
  input  logic               tx_underrun_i,
  input  logic               tx_enable_i,
  input  logic               send_abort_i,
  input  logic               clr_underrun_i,
  input  logic               clr_ext_irq_i,
  input  logic               async_mode_i,
  input  logic               xtal_sel_i,
  input  logic [NUM_SRC-1:0] ie_mask_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               ext_irq_o
);
  logic [NUM_LVL-1:0] pin_raw, pin_sync, live_v, block_v, arm_v;
  logic [NUM_LVL-1:0] lvl_trig, lvl_shown;
  logic               xtal_force, pend_q;
  logic               brk_bit, urun_bit, brk_trig, urun_trig;

  always_comb begin
    pin_raw           = '0;
    pin_raw[SRC_CTS]  = clear_to_send_i;
    pin_raw[SRC_DCD]  = carrier_det_i;
    pin_raw[SRC_SYNC] = sync_pin_i;
  end

  esm_sync #(.W(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_sync)
  );

  assign xtal_force = async_mode_i & xtal_sel_i;

  always_comb begin
    block_v           = '0;
    block_v[SRC_SYNC] = xtal_force;
    live_v            = pin_sync & ~block_v;
    arm_v             = ie_mask_i[NUM_LVL-1:0] & ~block_v;
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    esm_level_src u_src (
      .clk(clk), .rst_n(rst_n),
      .live_i(live_v[g]), .arm_i(arm_v[g]), .ie_i(ie_mask_i[g]),
      .hold_i(pend_q), .trig_o(lvl_trig[g]), .shown_o(lvl_shown[g])
    );
  end

  esm_event_src u_evt (
    .clk(clk), .rst_n(rst_n),
    .brk_i(brk_abort_i), .ie_brk_i(ie_mask_i[SRC_BRK]),
    .ie_urun_i(ie_mask_i[SRC_URUN]), .urun_evt_i(tx_underrun_i),
    .send_abort_i(send_abort_i), .clr_urun_i(clr_underrun_i),
    .tx_en_i(tx_enable_i),
    .brk_bit_o(brk_bit), .urun_bit_o(urun_bit),
    .brk_trig_o(brk_trig), .urun_trig_o(urun_trig)
  );

  // event sources override a same-cycle clear; pin sources need !pend
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~clr_ext_irq_i) | (|lvl_trig) | brk_trig | urun_trig;

  assign ext_irq_o = pend_q;

  always_comb begin
    status_o           = '0;
    status_o[BIT_BRK]  = brk_bit;
    status_o[BIT_URUN] = urun_bit;
    status_o[BIT_CTS]  = lvl_shown[SRC_CTS];
    status_o[BIT_DCD]  = lvl_shown[SRC_DCD];
    status_o[BIT_SYNC] = lvl_shown[SRC_SYNC] & ~xtal_force;
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_o && !clr_ext_irq_i |=> ext_irq_o);
  // R5
  brk_edge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie_mask_i[SRC_BRK] && !$stable(status_o[BIT_BRK]) |=> ext_irq_o);
  // R7
  urun_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[BIT_URUN]) && $past(ie_mask_i[SRC_URUN]) |-> ext_irq_o);
  // R8
  sync_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode_i && xtal_sel_i |-> !status_o[BIT_SYNC]);
endmodule

// File: tb/ext_status_monitor_test.sv
module ext_status_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts = 0, dcd = 0, syn = 0, brk = 0, urun_evt = 0, tx_en = 1;
  logic abort = 0, clr_urun = 0, clr_ext = 0, amode = 0, xtal = 0;
  logic [4:0] ie = '0;
  logic [7:0] status;
  logic irq;
  int vecs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_status_monitor uut (
    .clk(clk), .rst_n(rst_n), .clear_to_send_i(cts), .carrier_det_i(dcd),
    .sync_pin_i(syn), .brk_abort_i(brk), .tx_underrun_i(urun_evt),
    .tx_enable_i(tx_en), .send_abort_i(abort), .clr_underrun_i(clr_urun),
    .clr_ext_irq_i(clr_ext), .async_mode_i(amode), .xtal_sel_i(xtal),
    .ie_mask_i(ie), .status_o(status), .ext_irq_o(irq)
  );

  // behavioural reference: pin histories in queues, flags as bits
  bit hc[$], hd[$], hs[$], hb[$];
  bit m_pend, m_urun, m_txp;
  bit m_lat[3];

  function automatic bit at(ref bit q[$], input int i);
    return (q.size() > i) ? q[i] : 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc.delete(); hd.delete(); hs.delete(); hb.delete();
      m_pend = 0; m_urun = 1; m_txp = 1;
      foreach (m_lat[i]) m_lat[i] = 0;
    end else begin
      bit live[3];
      bit force_s, trig, set_u;
      force_s = amode && xtal;
      live[0] = at(hc, 1); live[1] = at(hd, 1);
      live[2] = force_s ? 1'b0 : at(hs, 1);
      trig = 0;
      for (int i = 0; i < 3; i++) begin
        bit armed;
        armed = ie[i] && !(i == 2 && force_s);
        if (armed && !m_pend && (live[i] != m_lat[i])) trig = 1;
      end
      if (ie[3] && (at(hb, 0) != at(hb, 1))) trig = 1;
      set_u = urun_evt || abort || (m_txp && !tx_en);
      if (ie[4] && set_u && !m_urun) trig = 1;
      if (!m_pend) for (int i = 0; i < 3; i++) m_lat[i] = live[i];
      m_pend = (m_pend && !clr_ext) || trig;
      if (set_u) m_urun = 1; else if (clr_urun) m_urun = 0;
      m_txp = tx_en;
      hc.push_front(cts); hd.push_front(dcd); hs.push_front(syn); hb.push_front(brk);
      while (hc.size() > 4) begin
        void'(hc.pop_back()); void'(hd.pop_back()); void'(hs.pop_back()); void'(hb.pop_back());
      end
    end
  end

  function automatic bit shown(int i, bit live);
    return (ie[i] && m_pend) ? m_lat[i] : live;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 irq", {7'b0, irq}, {7'b0, m_pend});
    chk("R5 brk bit", {7'b0, status[7]}, {7'b0, at(hb, 0)});
    chk("R6 urun bit", {7'b0, status[6]}, {7'b0, m_urun});
    chk("R2 cts bit", {7'b0, status[5]}, {7'b0, shown(0, at(hc, 1))});
    chk("R2 dcd bit", {7'b0, status[3]}, {7'b0, shown(1, at(hd, 1))});
    chk("R8 sync bit", {7'b0, status[4]},
        {7'b0, (amode && xtal) ? 1'b0 : shown(2, at(hs, 1))});
    chk("R1 low bits", {5'b0, status[2:0]}, 8'h00);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_ext();
    clr_ext = 1; cyc(1); clr_ext = 0;
  endtask

  task automatic report();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    // R1 reset state
    chk("R1 status", status, 8'h40);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R4 live view, two-cycle latency, no request
    cts = 1; cyc(1);
    chk("R4 cts early", {7'b0, status[5]}, 8'h00);
    cyc(1);
    chk("R4 cts live", {7'b0, status[5]}, 8'h01);
    dcd = 1; cyc(3);
    chk("R4 dcd live", {7'b0, status[3]}, 8'h01);
    chk("R4 no irq", {7'b0, irq}, 8'h00);
    cts = 0; dcd = 0; cyc(3);

    // R2 latch and freeze
    ie = 5'b00001; cyc(2);
    cts = 1; cyc(4);
    chk("R2 irq", {7'b0, irq}, 8'h01);
    chk("R2 latched", {7'b0, status[5]}, 8'h01);
    cts = 0; cyc(4);
    chk("R2 frozen", {7'b0, status[5]}, 8'h01);
    // R3 odd count re-raises
    clear_ext(); cyc(3);
    chk("R3 odd reraise", {7'b0, irq}, 8'h01);
    chk("R3 new capture", {7'b0, status[5]}, 8'h00);
    cts = 1; cyc(3); cts = 0; cyc(4);
    clear_ext(); cyc(3);
    chk("R3 even quiet", {7'b0, irq}, 8'h00);

    // R9 level persists
    ie = 5'b00010; dcd = 1; cyc(25);
    chk("R9 held", {7'b0, irq}, 8'h01);
    clear_ext(); cyc(3);
    chk("R9 cleared", {7'b0, irq}, 8'h00);

    // R5 both edges, edge beats clear
    ie = 5'b01000; brk = 1; cyc(3);
    chk("R5 rise irq", {7'b0, irq}, 8'h01);
    chk("R5 bit", {7'b0, status[7]}, 8'h01);
    brk = 0; cyc(1);
    clr_ext = 1; cyc(1); clr_ext = 0; cyc(2);
    chk("R5 fall beats clear", {7'b0, irq}, 8'h01);
    clear_ext(); cyc(2);
    chk("R5 quiet", {7'b0, irq}, 8'h00);

    // R6 / R7 underrun latch
    ie = 5'b10000;
    clr_urun = 1; cyc(1); clr_urun = 0; cyc(2);
    chk("R6 cleared", {7'b0, status[6]}, 8'h00);
    chk("R7 clear no irq", {7'b0, irq}, 8'h00);
    urun_evt = 1; cyc(1); urun_evt = 0; cyc(2);
    chk("R7 rise irq", {7'b0, irq}, 8'h01);
    clear_ext(); cyc(2);
    chk("R6 sticky", {7'b0, status[6]}, 8'h01);
    abort = 1; cyc(1); abort = 0; cyc(2);
    chk("R7 already set", {7'b0, irq}, 8'h00);
    clr_urun = 1; cyc(1); clr_urun = 0;
    abort = 1; clr_urun = 1; cyc(1); abort = 0; clr_urun = 0; cyc(2);
    chk("R6 set wins", {7'b0, status[6]}, 8'h01);
    chk("R7 abort irq", {7'b0, irq}, 8'h01);
    clear_ext(); ie = 5'b00000;
    clr_urun = 1; cyc(1); clr_urun = 0;
    tx_en = 0; cyc(2);
    chk("R6 tx disable", {7'b0, status[6]}, 8'h01);
    chk("R7 masked", {7'b0, irq}, 8'h00);
    tx_en = 1; cyc(2);

    // R8 crystal force
    ie = 5'b00100; amode = 1; xtal = 1; syn = 1; cyc(5);
    chk("R8 forced bit", {7'b0, status[4]}, 8'h00);
    chk("R8 no irq", {7'b0, irq}, 8'h00);
    xtal = 0; cyc(3);
    chk("R8 released", {7'b0, irq}, 8'h01);
    clear_ext(); cyc(2);

    // randomized sweep compared every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 5) == 0) cts = ~cts;
      if ($urandom_range(0, 5) == 0) dcd = ~dcd;
      if ($urandom_range(0, 5) == 0) syn = ~syn;
      if ($urandom_range(0, 7) == 0) brk = ~brk;
      urun_evt = ($urandom_range(0, 15) == 0);
      abort    = ($urandom_range(0, 19) == 0);
      clr_urun = ($urandom_range(0, 6) == 0);
      clr_ext  = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 9) == 0) tx_en = ~tx_en;
      if ($urandom_range(0, 40) == 0) amode = ~amode;
      if ($urandom_range(0, 30) == 0) xtal = ~xtal;
      if ($urandom_range(0, 25) == 0) ie = 5'($urandom);
      cyc(1);
    end
    urun_evt = 0; abort = 0; clr_urun = 0; clr_ext = 0;
    cyc(2);
    report();
  end
endmodule